// File: doc/BRIEF.md
# Nestable Interrupt Controller with Vector Registers

This controller serves a processor sequencer that has no hardware return-address stack. It holds a pending bit for each hardware request line and an enable bit for each line. Among the enabled pending requests it chooses the lowest index. When it accepts that request it presents the handler address taken from an internal table of vector registers. It copies the sequencer's current PC into an interrupt return register. It marks the level as in service and raises a global block, which keeps every further hardware request waiting.

Nesting is left to software and has no enable bit. Reading the return register through its alias register lets software save that register, and the same read drops the global block. From then on a request of higher priority than every in-service level can preempt the running handler. Writing the alias back restores the register and raises the block again, so the handler's epilogue cannot be interrupted. The sequencer ends a handler through a return strobe. The strobe can do a normal return, a return that leaves the in-service bits alone, a "reduce to subroutine" that only releases the current level, or a return from a software exception.

Software exceptions outrank every hardware request and are accepted even while the block is raised. They share one handler vector and save the PC into a separate return register. A trap carries a 5-bit code that is kept in a status field, and a separate cause field records why the exception was taken.

Top module: `intc_top`

## Requirements
- R1: A high request line sets its pending bit at the next clock edge. Reading address 34 returns the pending bits. Writing address 34 sets the pending bits that are 1 in the write data, and writing address 35 clears them. The pending bit of a request is cleared when that request is accepted.
- R2: Of the pending bits whose enable bit (address 33) is 1, the lowest index wins. A pending request whose enable bit is 0 is never accepted and stays pending.
- R3: A request latched at clock edge k is accepted at edge k+1, and the following outputs are updated at that edge: `vec_valid` pulses for one cycle, `vec_addr` equals vector register i (addresses 0..NUM_IRQ-1), `vec_is_exc` is 0, the interrupt return register takes `pc_in`, in-service bit i (read at address 36) is set, and `gblock` goes to 1.
- R4: While `gblock` is 1, no hardware request is accepted. A read strobe at the alias address 37 returns the interrupt return register and clears `gblock`.
- R5: A write to the alias address 37 loads the interrupt return register and sets `gblock`.
- R6: A hardware request is accepted only if its index is lower than the index of every set in-service bit. A request of equal or lower priority waits.
- R7: Return operation 1 (normal return) pulses `ret_valid` with `ret_addr` equal to the interrupt return register. It clears the lowest-index set in-service bit and clears `gblock`.
- R8: Return operation 2 pulses `ret_valid` with the interrupt return register and clears `gblock`. It leaves the in-service bits unchanged.
- R9: Return operation 3 (reduce to subroutine) clears the lowest-index set in-service bit. It does not pulse `ret_valid` and leaves `gblock` unchanged.
- R10: `exc_req` or `trap_req` is accepted in the same cycle, before any hardware request and regardless of `gblock`. On acceptance `vec_addr` takes the software vector (address 32), `vec_is_exc` is 1, the software return register (address 38) takes `pc_in`, and `gblock` is set.
- R11: The status register at address 39 holds the trap code in bits 12:8, the cause in bits 3:0 and `gblock` in bit 31. A trap stores its code and cause 1, and takes precedence over `exc_req` when both are high. An `exc_req` without a trap stores `exc_cause` and leaves the trap field unchanged.
- R12: Return operation 4 pulses `ret_valid` with `ret_addr` equal to the software return register and clears `gblock`. While any return operation is presented, no hardware request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | NUM_IRQ | Hardware request lines |
| pc_in | input | DW | Current sequencer PC |
| ret_op | input | 3 | Return operation: 0 none, 1 normal, 2 keep in-service, 3 reduce, 4 exception return |
| exc_req | input | 1 | Software exception request |
| exc_cause | input | 4 | Cause code for exc_req |
| trap_req | input | 1 | Trap instruction request |
| trap_code | input | 5 | Trap code |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect at alias) |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data (combinational) |
| vec_valid | output | 1 | Handler entry pulse |
| vec_is_exc | output | 1 | Entry is a software exception |
| vec_addr | output | DW | Handler address |
| ret_valid | output | 1 | Return pulse |
| ret_addr | output | DW | Return address |
| gblock | output | 1 | Global hardware-request block |

## Verification
The bench walks every request line through a full entry and return. This would expose a vector table with a wrong index, a pending bit that is not cleared on acceptance, or an in-service bit at the wrong position. It then builds a nested case. A lower-priority request must wait through both the block and the in-service bit of the running level. A design that compared priority against the wrong end of the in-service vector would let it through early, and one that ignored the alias read would never allow the higher-priority nest. It also collides a trap with a hardware request in one cycle and takes an exception while the block is raised, which catches an arbiter that ranks software exceptions below hardware requests or lets the block gate them.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef enum logic [2:0] {
    RET_NONE   = 3'd0,
    RET_RTI    = 3'd1,
    RET_KEEP   = 3'd2,
    RET_REDUCE = 3'd3,
    RET_EXC    = 3'd4
  } ret_op_e;

  localparam logic [5:0] A_SWVEC = 6'd32;
  localparam logic [5:0] A_EN    = 6'd33;
  localparam logic [5:0] A_LSET  = 6'd34;
  localparam logic [5:0] A_LCLR  = 6'd35;
  localparam logic [5:0] A_MP    = 6'd36;
  localparam logic [5:0] A_ALIAS = 6'd37;
  localparam logic [5:0] A_SWRET = 6'd38;
  localparam logic [5:0] A_STAT  = 6'd39;
  localparam logic [3:0] TRAP_CAUSE = 4'h1;

  // index of lowest set bit, 32 when none
  function automatic logic [5:0] lowest_idx(input logic [31:0] v);
    lowest_idx = 6'd32;
    for (int i = 31; i >= 0; i--)
      if (v[i]) lowest_idx = 6'(i);
  endfunction

  function automatic logic [31:0] drop_lowest(input logic [31:0] v);
    return v & (v - 32'd1);
  endfunction
endpackage

// File: rtl/intc_pend.sv
module intc_pend #(
  parameter int N  = 30,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  irq_req,
  input  logic [N-1:0]  set_bits,
  input  logic [N-1:0]  clr_bits,
  input  logic [N-1:0]  take_bits,
  input  logic          en_wr,
  input  logic [DW-1:0] en_wdata,
  output logic [N-1:0]  latch,
  output logic [N-1:0]  enable
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch  <= '0;
      enable <= '0;
    end else begin
      latch <= ((latch & ~take_bits) | irq_req | set_bits) & ~clr_bits;
      if (en_wr) enable <= en_wdata[N-1:0];
    end
  end
endmodule

// File: rtl/intc_vtab.sv
module intc_vtab #(
  parameter int N  = 30,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [4:0]    wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [4:0]    a_idx,
  output logic [DW-1:0] a_data,
  input  logic [4:0]    b_idx,
  output logic [DW-1:0] b_data
);
  logic [DW-1:0] tab [N];

  for (genvar g = 0; g < N; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tab[g] <= '0;
      else if (wr_en && wr_idx == 5'(g)) tab[g] <= wr_data;
    end
  end

  always_comb begin
    a_data = '0;
    b_data = '0;
    for (int i = 0; i < N; i++) begin
      if (a_idx == 5'(i)) a_data = tab[i];
      if (b_idx == 5'(i)) b_data = tab[i];
    end
  end
endmodule

// File: rtl/intc_mask.sv
module intc_mask
  import intc_pkg::*;
#(
  parameter int N = 30
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] take_bits,
  input  logic         hw_take,
  input  logic         sw_take,
  input  logic [2:0]   ret_op,
  input  logic         alias_rd,
  input  logic         alias_wr,
  output logic [N-1:0] mp,
  output logic         gblock
);
  logic blk_set, blk_clr;
  assign blk_set = hw_take | sw_take | alias_wr;
  assign blk_clr = alias_rd | (ret_op == RET_RTI) | (ret_op == RET_KEEP) |
                   (ret_op == RET_EXC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mp     <= '0;
      gblock <= 1'b0;
    end else begin
      if (hw_take) mp <= mp | take_bits;
      else if (ret_op == RET_RTI || ret_op == RET_REDUCE)
        mp <= N'(drop_lowest(32'(mp)));
      if (blk_set)      gblock <= 1'b1;
      else if (blk_clr) gblock <= 1'b0;
    end
  end
endmodule

// File: rtl/intc_top.sv
module intc_top
  import intc_pkg::*;
#(
  parameter int NUM_IRQ = 30,
  parameter int DW      = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic [DW-1:0]      pc_in,
  input  logic [2:0]         ret_op,
  input  logic               exc_req,
  input  logic [3:0]         exc_cause,
  input  logic               trap_req,
  input  logic [4:0]         trap_code,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [5:0]         reg_addr,
  input  logic [DW-1:0]      reg_wdata,
  output logic [DW-1:0]      reg_rdata,
  output logic               vec_valid,
  output logic               vec_is_exc,
  output logic [DW-1:0]      vec_addr,
  output logic               ret_valid,
  output logic [DW-1:0]      ret_addr,
  output logic               gblock
);
  localparam logic [5:0] NL = 6'(NUM_IRQ);

  logic [NUM_IRQ-1:0] latch, enable, mp, take_bits, set_bits, clr_bits;
  logic [5:0]  hw_idx, mp_low;
  logic        hw_take, sw_take, alias_rd, alias_wr, keep_op;
  logic [DW-1:0] hw_vec, tab_rd, iret, swret, swvec;
  logic [4:0]  trap_q;
  logic [3:0]  cause_q;

  // decision wires, also watched by the checker
  assign hw_idx   = lowest_idx(32'(latch & enable));
  assign mp_low   = lowest_idx(32'(mp));
  assign sw_take  = exc_req | trap_req;
  assign hw_take  = (hw_idx < NL) && (hw_idx < mp_low) && !gblock &&
                    !sw_take && (ret_op == RET_NONE);
  assign take_bits = hw_take ? (NUM_IRQ'(1) << hw_idx) : '0;
  assign alias_rd = reg_rd && reg_addr == A_ALIAS;
  assign alias_wr = reg_wr && reg_addr == A_ALIAS;
  assign keep_op  = ret_op == RET_KEEP;
  assign set_bits = (reg_wr && reg_addr == A_LSET) ? reg_wdata[NUM_IRQ-1:0] : '0;
  assign clr_bits = (reg_wr && reg_addr == A_LCLR) ? reg_wdata[NUM_IRQ-1:0] : '0;

  intc_pend #(.N(NUM_IRQ), .DW(DW)) u_pend (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .set_bits(set_bits),
    .clr_bits(clr_bits), .take_bits(take_bits),
    .en_wr(reg_wr && reg_addr == A_EN), .en_wdata(reg_wdata),
    .latch(latch), .enable(enable));

  intc_vtab #(.N(NUM_IRQ), .DW(DW)) u_vtab (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr && !reg_addr[5]),
    .wr_idx(reg_addr[4:0]), .wr_data(reg_wdata),
    .a_idx(hw_idx[4:0]), .a_data(hw_vec),
    .b_idx(reg_addr[4:0]), .b_data(tab_rd));

  intc_mask #(.N(NUM_IRQ)) u_mask (
    .clk(clk), .rst_n(rst_n), .take_bits(take_bits), .hw_take(hw_take),
    .sw_take(sw_take), .ret_op(ret_op), .alias_rd(alias_rd),
    .alias_wr(alias_wr), .mp(mp), .gblock(gblock));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iret <= '0; swret <= '0; swvec <= '0;
      trap_q <= '0; cause_q <= '0;
      vec_valid <= 1'b0; vec_is_exc <= 1'b0; vec_addr <= '0;
      ret_valid <= 1'b0; ret_addr <= '0;
    end else begin
      if (hw_take)       iret <= pc_in;
      else if (alias_wr) iret <= reg_wdata;
      if (sw_take) swret <= pc_in;
      else if (reg_wr && reg_addr == A_SWRET) swret <= reg_wdata;
      if (reg_wr && reg_addr == A_SWVEC) swvec <= reg_wdata;
      if (trap_req) begin
        trap_q  <= trap_code;
        cause_q <= TRAP_CAUSE;
      end else if (exc_req) begin
        cause_q <= exc_cause;
      end
      vec_valid  <= hw_take | sw_take;
      vec_is_exc <= sw_take;
      if (sw_take)      vec_addr <= swvec;
      else if (hw_take) vec_addr <= hw_vec;
      ret_valid <= (ret_op == RET_RTI) || keep_op || (ret_op == RET_EXC);
      if (ret_op == RET_EXC) ret_addr <= swret;
      else if (ret_op == RET_RTI || keep_op) ret_addr <= iret;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (!reg_addr[5]) reg_rdata = tab_rd;
    else case (reg_addr)
      A_SWVEC: reg_rdata = swvec;
      A_EN:    reg_rdata = DW'(enable);
      A_LSET, A_LCLR: reg_rdata = DW'(latch);
      A_MP:    reg_rdata = DW'(mp);
      A_ALIAS: reg_rdata = iret;
      A_SWRET: reg_rdata = swret;
      A_STAT:  reg_rdata = DW'({gblock, 18'd0, trap_q, 4'd0, cause_q});
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/intc_chk.sv
module intc_chk #(
  parameter int N = 30
) (
  input logic         clk,
  input logic         rst_n,
  input logic         hw_take,
  input logic         sw_take,
  input logic         alias_rd,
  input logic         alias_wr,
  input logic         keep_op,
  input logic [N-1:0] mp,
  input logic         gblock,
  input logic         vec_valid,
  input logic         ret_valid
);
  // R3
  entry_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> gblock);
  // R3
  mp_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_take |=> ($countones(mp) == $countones($past(mp)) + 1));
  // R4
  unblock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alias_rd && !hw_take && !sw_take && !alias_wr) |=> !gblock);
  // R5
  reblock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alias_wr |=> gblock);
  // R8
  keep_mp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    keep_op |=> (mp == $past(mp)));
  // R12
  ret_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |-> !vec_valid);
endmodule

bind intc_top intc_chk #(.N(NUM_IRQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .hw_take(hw_take), .sw_take(sw_take),
  .alias_rd(alias_rd), .alias_wr(alias_wr), .keep_op(keep_op), .mp(mp),
  .gblock(gblock), .vec_valid(vec_valid), .ret_valid(ret_valid));

// File: tb/sim_intc_top.sv
`timescale 1ns/1ps
module sim_intc_top;
  import intc_pkg::*;
  localparam int N = 30;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] irq_req = '0;
  logic [31:0] pc_in = '0, reg_wdata = '0, reg_rdata, vec_addr, ret_addr;
  logic [2:0] ret_op = '0;
  logic exc_req = 0, trap_req = 0, reg_wr = 0, reg_rd = 0;
  logic [3:0] exc_cause = '0;
  logic [4:0] trap_code = '0;
  logic [5:0] reg_addr = '0;
  logic vec_valid, vec_is_exc, ret_valid, gblock;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  intc_top #(.NUM_IRQ(N), .DW(32)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .pc_in(pc_in),
    .ret_op(ret_op), .exc_req(exc_req), .exc_cause(exc_cause),
    .trap_req(trap_req), .trap_code(trap_code), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .vec_valid(vec_valid), .vec_is_exc(vec_is_exc),
    .vec_addr(vec_addr), .ret_valid(ret_valid), .ret_addr(ret_addr),
    .gblock(gblock));

  function automatic logic [31:0] vec_of(int i);
    return 32'h1000 + 32'(i) * 32'h10;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick; @(posedge clk); #1; endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1; tick; reg_wr = 0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    reg_addr = a; #0.5; d = reg_rdata;
  endtask

  task automatic rd_alias(output logic [31:0] d);
    reg_addr = A_ALIAS; reg_rd = 1; #0.5; d = reg_rdata; tick; reg_rd = 0;
  endtask

  task automatic pulse(int i);
    irq_req[i] = 1'b1; tick; irq_req = '0;
  endtask

  task automatic do_ret(logic [2:0] op);
    ret_op = op; tick; ret_op = RET_NONE;
  endtask

  initial begin
    #500000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    tick; tick; rst_n = 1; tick;
    // reset state
    chk("R3 reset vec_valid", 32'(vec_valid), 0);
    chk("R4 reset gblock", 32'(gblock), 0);
    rd(A_MP, d);   chk("R3 reset mp", d, 0);
    rd(A_LSET, d); chk("R1 reset latch", d, 0);

    for (int i = 0; i < N; i++) wr(6'(i), vec_of(i));
    wr(A_SWVEC, 32'h8000);
    wr(A_EN, 32'hFFFF_FFFF);

    // R3 R7: every line through entry and normal return
    for (int i = 0; i < N; i++) begin
      pc_in = 32'h4000 + 32'(i);
      pulse(i); tick;
      chk("R3 vec_valid", 32'(vec_valid), 1);
      chk("R3 vec_addr", vec_addr, vec_of(i));
      chk("R3 gblock", 32'(gblock), 1);
      rd(A_MP, d);   chk("R3 mp bit", d, 32'(1) << i);
      rd(A_LSET, d); chk("R1 latch cleared on accept", d, 0);
      rd(A_ALIAS, d); chk("R3 iret", d, 32'h4000 + 32'(i));
      do_ret(RET_RTI);
      chk("R7 ret_valid", 32'(ret_valid), 1);
      chk("R7 ret_addr", ret_addr, 32'h4000 + 32'(i));
      chk("R7 gblock cleared", 32'(gblock), 0);
      rd(A_MP, d); chk("R7 mp cleared", d, 0);
    end

    // R2 priority, R4 block, R6 nesting
    pc_in = 32'h5000;
    irq_req[2] = 1; irq_req[5] = 1; tick; irq_req = '0; tick;
    chk("R2 lowest index wins", vec_addr, vec_of(2));
    tick; tick; tick;
    chk("R4 blocked while gblock", 32'(vec_valid), 0);
    rd(A_LSET, d); chk("R4 irq5 still pending", d, 32'h20);
    rd_alias(d);   chk("R4 alias read value", d, 32'h5000);
    chk("R4 alias read clears gblock", 32'(gblock), 0);
    tick; tick;
    chk("R6 lower priority waits", 32'(vec_valid), 0);
    pc_in = 32'h5100;
    pulse(1); tick;
    chk("R6 higher priority nests", vec_addr, vec_of(1));
    rd(A_MP, d); chk("R6 mp two levels", d, 32'h6);
    rd_alias(d); chk("R4 alias value nested", d, 32'h5100);
    wr(A_ALIAS, 32'h5234);
    chk("R5 alias write sets gblock", 32'(gblock), 1);
    do_ret(RET_RTI);
    chk("R7 ret_addr after restore", ret_addr, 32'h5234);
    rd(A_MP, d); chk("R7 lowest mp bit cleared", d, 32'h4);
    tick; tick;
    chk("R6 still waits behind level 2", 32'(vec_valid), 0);
    do_ret(RET_KEEP);
    chk("R8 ret_addr", ret_addr, 32'h5234);
    rd(A_MP, d); chk("R8 mp unchanged", d, 32'h4);
    chk("R8 gblock cleared", 32'(gblock), 0);
    do_ret(RET_REDUCE);
    chk("R9 no ret_valid", 32'(ret_valid), 0);
    rd(A_MP, d); chk("R9 mp released", d, 0);
    tick;
    chk("R9 waiting irq now taken", vec_addr, vec_of(5));
    chk("R9 taken valid", 32'(vec_valid), 1);
    do_ret(RET_RTI);
    chk("R7 ret to capture pc", ret_addr, 32'h5100);

    // R1 R2 enable and software latch access
    wr(A_EN, 32'hFFFF_FFF7);
    pulse(3); tick; tick;
    chk("R2 disabled not taken", 32'(vec_valid), 0);
    rd(A_LSET, d); chk("R1 disabled stays pending", d, 32'h8);
    wr(A_LCLR, 32'h8);
    rd(A_LSET, d); chk("R1 software clear", d, 0);
    wr(A_LSET, 32'h80); tick;
    chk("R1 software set taken", vec_addr, vec_of(7));
    rd(A_LSET, d); chk("R1 set bit cleared on accept", d, 0);
    do_ret(RET_RTI);
    wr(A_EN, 32'hFFFF_FFFF);

    // R10 R11 R12 exceptions
    pc_in = 32'h6000;
    trap_req = 1; trap_code = 5'h1B; irq_req[0] = 1; tick;
    trap_req = 0; irq_req = '0;
    chk("R10 exception outranks", 32'(vec_is_exc), 1);
    chk("R10 sw vector", vec_addr, 32'h8000);
    rd(A_STAT, d); chk("R11 trap status", d, 32'h8000_1B01);
    rd(A_SWRET, d); chk("R10 swret", d, 32'h6000);
    do_ret(RET_EXC);
    chk("R12 ret_addr", ret_addr, 32'h6000);
    chk("R12 gblock cleared", 32'(gblock), 0);
    tick;
    chk("R10 hw after exception", vec_addr, vec_of(0));
    chk("R10 hw kind", 32'(vec_is_exc), 0);
    pc_in = 32'h6100;
    exc_req = 1; exc_cause = 4'h6; tick; exc_req = 0;
    chk("R10 taken while blocked", 32'(vec_is_exc & vec_valid), 1);
    rd(A_STAT, d); chk("R11 exc cause", d, 32'h8000_1B06);
    do_ret(RET_EXC);
    chk("R12 ret_addr exc", ret_addr, 32'h6100);
    do_ret(RET_RTI);
    chk("R7 ret after exc", ret_addr, 32'h6000);
    rd(A_MP, d); chk("R7 final mp", d, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule